// File: doc/BRIEF.md
# Priority interrupt request arbiter

This block decides which pending interrupt source is shown to the processor. It keeps a pending flag for every source and a single slot that holds the request currently outstanding. When the slot is empty, an enabled, nonzero source that has just been flagged is loaded into the slot directly. When the processor acknowledges, the slot is emptied and every pending flag is scanned. The source with the highest mapped priority is then loaded, as long as it is enabled. The outstanding request is presented as one word that holds the priority above the vector number. That word goes out on the normal request line, or on a separate fast line when fast steering is switched on and the vector matches the programmed fast vector.

Trigger detection stays outside the block. For each source, the block receives a raise input and a flag that marks the source as level-sensitive. An edge source pulses its raise input for one cycle per event. A level source holds its raise input high for as long as it is asserted. Each source finds its priority through a per-source index into a shared array of priority registers.

Top module: `irq_req_arbiter`

## Requirements
- R1: During and after synchronous reset, both output lines read zero and no request is outstanding.
- R2: The outstanding request is presented as the word {priority[3:0], vector[7:0]}, with the priority in bits 11:8 and the vector in bits 7:0. A word of zero means no request.
- R3: An event loads the slot only if the source is enabled (bit n of the enable vector) and the slot is empty. Among events that arrive in the same cycle, the lowest-numbered eligible source wins, whatever its priority.
- R4: Source 0 is never loaded into the slot.
- R5: When fast steering is enabled and the outstanding vector equals the fast vector, the word appears on the fast line and the normal line reads zero. Otherwise the word appears on the normal line and the fast line reads zero. Steering follows the current fast settings.
- R6: An acknowledge empties the slot. It also clears the acknowledged source's pending flag if that source is edge-sensitive. A level-sensitive source keeps its flag for as long as its raise input is high.
- R7: On the cycle after an acknowledge, the slot holds the pending source whose priority is strictly greater than that of every lower-numbered pending source and at least as great as that of every higher-numbered one. Priority 0 is never chosen, and on equal priority the lowest number wins.
- R8: If the source chosen by the post-acknowledge scan is disabled (or is source 0), the slot stays empty, even when an enabled source with lower priority is pending.
- R9: An acknowledge while the slot is empty changes nothing.
- R10: If a level-sensitive source that is outstanding drops its raise input, the slot empties on the next cycle and both lines read zero.
- R11: A source's priority is the entry of the priority array selected by that source's map index. Sources that share an index share a priority.
- R12: While the slot is occupied and no acknowledge arrives, new events stay pending and do not replace the outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | NUM_SRC | Per-source raise: a one-cycle pulse for edge sources, the held level for level sources |
| lvl_sens_i | input | NUM_SRC | 1 marks a source as level-sensitive |
| en_i | input | NUM_SRC | Per-source enable |
| map_i | input | NUM_SRC*MAP_W | Per-source index into the priority array |
| prio_i | input | NUM_PRIO_REG*4 | Priority array, 4 bits per entry |
| fast_en_i | input | 1 | Enables steering to the fast line |
| fast_vec_i | input | 8 | Vector that is steered to the fast line |
| ack_i | input | 1 | Processor acknowledge, one cycle |
| req_o | output | 12 | Normal request word |
| fast_o | output | 12 | Fast request word |

## Verification
The bench builds the arbiter with 16 sources and 8 priority entries. The map index of source n is n mod 8, so sources n and n+8 share a priority. This brings sharing through the map, ties between different entries at one priority, and a zero-priority source all within reach of short directed sequences. The bench also gives the top-priority entry to a source that it disables. Source 9 is the only level-sensitive source, which makes the drop and re-request paths visible next to edge behaviour.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int IRQ_PRIO_W = 4;
    localparam int IRQ_VEC_W  = 8;
    localparam int IRQ_WORD_W = IRQ_PRIO_W + IRQ_VEC_W;

    typedef logic [IRQ_PRIO_W-1:0] prio_t;
    typedef logic [IRQ_VEC_W-1:0]  vec_t;
    typedef logic [IRQ_WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        prio_t prio;
        vec_t  vec;
    } slot_t;

    typedef enum logic [1:0] {
        SLOT_HOLD,
        SLOT_LOAD,
        SLOT_RESCAN,
        SLOT_DROP
    } slot_op_e;

    function automatic word_t pack_word(slot_t s);
        return s.valid ? {s.prio, s.vec} : '0;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] raise_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] pend_nxt,
    output logic [NUM_SRC-1:0] evt_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Level sources follow their input; edge sources are sticky until acknowledged.
        always_comb begin
            if (lvl_i[g]) begin
                pend_nxt[g] = raise_i[g];
                evt_o[g]    = raise_i[g] & ~pend_q[g];
            end else begin
                pend_nxt[g] = raise_i[g] | (pend_q[g] & ~clr_i[g]);
                evt_o[g]    = raise_i[g];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) pend_q[g] <= 1'b0;
            else     pend_q[g] <= pend_nxt[g];
        end

        a_r6_edge_flag_cleared: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !raise_i[g] && !lvl_i[g]) |=> !pend_q[g]);
    end

endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter bit FIRST_WINS = 1'b0
) (
    input  logic [NUM_SRC-1:0]        cand_i,
    input  prio_t [NUM_SRC-1:0]       prio_i,
    output logic                      found_o,
    output vec_t                      idx_o,
    output prio_t                     prio_o
);

    if (FIRST_WINS) begin : g_first
        // Lowest-numbered candidate, priority ignored.
        always_comb begin
            found_o = 1'b0;
            idx_o   = '0;
            prio_o  = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (cand_i[i]) begin
                    found_o = 1'b1;
                    idx_o   = IRQ_VEC_W'(i);
                    prio_o  = prio_i[i];
                end
            end
        end
    end else begin : g_best
        // Strictly-greater search from zero: ties keep the lower index.
        always_comb begin
            found_o = 1'b0;
            idx_o   = '0;
            prio_o  = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (cand_i[i] && (prio_i[i] > prio_o)) begin
                    found_o = 1'b1;
                    idx_o   = IRQ_VEC_W'(i);
                    prio_o  = prio_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/irq_out_route.sv
module irq_out_route
    import irq_arb_pkg::*;
(
    input  slot_t slot_i,
    input  logic  fast_en_i,
    input  vec_t  fast_vec_i,
    output word_t req_o,
    output word_t fast_o
);

    word_t word;
    logic  to_fast;

    always_comb begin
        word    = pack_word(slot_i);
        to_fast = fast_en_i && (slot_i.vec == fast_vec_i);
        req_o   = to_fast ? '0 : word;
        fast_o  = to_fast ? word : '0;
    end

endmodule

// File: rtl/irq_req_arbiter.sv
module irq_req_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC      = 32,
    parameter int NUM_PRIO_REG = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_SRC-1:0]                 raise_i,
    input  logic [NUM_SRC-1:0]                 lvl_sens_i,
    input  logic [NUM_SRC-1:0]                 en_i,
    input  logic [NUM_SRC*$clog2(NUM_PRIO_REG)-1:0] map_i,
    input  logic [NUM_PRIO_REG*IRQ_PRIO_W-1:0] prio_i,
    input  logic                               fast_en_i,
    input  logic [IRQ_VEC_W-1:0]               fast_vec_i,
    input  logic                               ack_i,
    output logic [IRQ_WORD_W-1:0]              req_o,
    output logic [IRQ_WORD_W-1:0]              fast_o
);

    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int MAP_W = $clog2(NUM_PRIO_REG);

    slot_t                slot_q, slot_d;
    slot_op_e             op;
    logic [SRC_W-1:0]     cur;
    prio_t [NUM_SRC-1:0]  prio_of;
    logic [NUM_SRC-1:0]   clr, pend_q, pend_nxt, evt, evt_ok;
    logic                 evt_found, scan_found;
    vec_t                 evt_idx, scan_idx;
    prio_t                evt_prio, scan_prio;
    logic                 cur_dropped, scan_ok;

    assign cur = slot_q.vec[SRC_W-1:0];

    // Per-source priority through the map index.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
        logic [MAP_W-1:0] sel;
        assign sel = map_i[g*MAP_W +: MAP_W];
        assign prio_of[g] = (32'(sel) < NUM_PRIO_REG) ? prio_i[sel*IRQ_PRIO_W +: IRQ_PRIO_W] : '0;
    end

    always_comb begin
        clr = '0;
        if (ack_i && slot_q.valid) clr[cur] = 1'b1;
    end

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .raise_i  (raise_i),
        .lvl_i    (lvl_sens_i),
        .clr_i    (clr),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt),
        .evt_o    (evt)
    );

    assign evt_ok = {evt[NUM_SRC-1:1] & en_i[NUM_SRC-1:1], 1'b0};

    irq_prio_scan #(.NUM_SRC(NUM_SRC), .FIRST_WINS(1'b1)) u_evt_pick (
        .cand_i  (evt_ok),
        .prio_i  (prio_of),
        .found_o (evt_found),
        .idx_o   (evt_idx),
        .prio_o  (evt_prio)
    );

    irq_prio_scan #(.NUM_SRC(NUM_SRC), .FIRST_WINS(1'b0)) u_rescan (
        .cand_i  (pend_nxt),
        .prio_i  (prio_of),
        .found_o (scan_found),
        .idx_o   (scan_idx),
        .prio_o  (scan_prio)
    );

    assign cur_dropped = lvl_sens_i[cur] && !raise_i[cur];
    assign scan_ok     = scan_found && en_i[scan_idx[SRC_W-1:0]] && (scan_idx != '0);

    always_comb begin
        if (ack_i && slot_q.valid)               op = SLOT_RESCAN;
        else if (slot_q.valid && cur_dropped)    op = SLOT_DROP;
        else if (!slot_q.valid && evt_found)     op = SLOT_LOAD;
        else                                     op = SLOT_HOLD;
    end

    always_comb begin
        slot_d = slot_q;
        unique case (op)
            SLOT_RESCAN: slot_d = '{valid: scan_ok, prio: scan_prio, vec: scan_idx};
            SLOT_DROP:   slot_d = '0;
            SLOT_LOAD:   slot_d = '{valid: 1'b1, prio: evt_prio, vec: evt_idx};
            default:     slot_d = slot_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    irq_out_route u_route (
        .slot_i     (slot_q),
        .fast_en_i  (fast_en_i),
        .fast_vec_i (fast_vec_i),
        .req_o      (req_o),
        .fast_o     (fast_o)
    );

    a_r1_reset_empty: assert property (@(posedge clk) rst |=> !slot_q.valid);

    a_r4_no_zero_vector: assert property (@(posedge clk) disable iff (rst)
        slot_q.valid |-> (slot_q.vec != '0));

    a_r5_single_line: assert property (@(posedge clk) disable iff (rst)
        !((req_o != '0) && (fast_o != '0)));

    a_r7_rescan_nonzero_prio: assert property (@(posedge clk) disable iff (rst)
        (ack_i && slot_q.valid) |=> (!slot_q.valid || slot_q.prio != '0));

    a_r9_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (!slot_q.valid && ack_i && !evt_found) |=> !slot_q.valid);

    a_r10_level_drop: assert property (@(posedge clk) disable iff (rst)
        (slot_q.valid && !ack_i && cur_dropped) |=> (req_o == '0 && fast_o == '0));

    a_r12_slot_held: assert property (@(posedge clk) disable iff (rst)
        (slot_q.valid && !ack_i && !cur_dropped) |=> $stable(slot_q));

endmodule

// File: tb/irq_req_arbiter_tb.sv
`timescale 1ns/100ps
module irq_req_arbiter_tb_top;

    localparam int N  = 16;
    localparam int NP = 8;
    localparam int MW = 3;
    localparam int PW = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    raise, lvl, en;
    logic [N*MW-1:0] map;
    logic [NP*PW-1:0] prio;
    logic            fast_en, ack;
    logic [7:0]      fast_vec;
    logic [11:0]     req, fast;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_req_arbiter #(.NUM_SRC(N), .NUM_PRIO_REG(NP)) dut_i (
        .clk(clk), .rst(rst), .raise_i(raise), .lvl_sens_i(lvl), .en_i(en),
        .map_i(map), .prio_i(prio), .fast_en_i(fast_en), .fast_vec_i(fast_vec),
        .ack_i(ack), .req_o(req), .fast_o(fast)
    );

    task automatic check(input string tag, input logic [11:0] exp_req, input logic [11:0] exp_fast);
        checks++;
        if (req !== exp_req || fast !== exp_fast) begin
            errors++;
            $display("FAIL %s: req=%h fast=%h expected req=%h fast=%h", tag, req, fast, exp_req, exp_fast);
        end
    endtask

    // Entry values: 0,3,7,5,2,4,4,6 ; source n uses entry n%8.
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; raise = '0; ack = 1'b0; en = '1; fast_en = 1'b0; fast_vec = '0;
        lvl = '0; lvl[9] = 1'b1;
        prio = {4'd6, 4'd4, 4'd4, 4'd2, 4'd5, 4'd7, 4'd3, 4'd0};
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        raise = bits;
        @(negedge clk);
        raise = '0;
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_and_basic();
        do_reset();
        check("R1 reset state", 12'h000, 12'h000);
        pulse(16'h0008);
        check("R2 word of source 3", 12'h503, 12'h000);
        do_ack();
        check("R6 edge flag cleared on ack", 12'h000, 12'h000);
        pulse(16'h0800);
        check("R11 source 11 shares entry 3", 12'h50B, 12'h000);
        prio[3*PW +: PW] = 4'd1;
        do_ack();
        pulse(16'h0800);
        check("R11 entry change seen by source 11", 12'h10B, 12'h000);
    endtask

    task automatic t_simultaneous();
        do_reset();
        pulse(16'h0050);
        check("R3 lowest simultaneous wins", 12'h204, 12'h000);
        do_ack();
        check("R7 rescan picks pending 6", 12'h406, 12'h000);
        do_ack();
        check("R7 nothing left", 12'h000, 12'h000);
    endtask

    task automatic t_hold_and_tie();
        do_reset();
        pulse(16'h0010);
        pulse(16'h0080);
        check("R12 new event does not replace", 12'h204, 12'h000);
        do_ack();
        check("R7 higher pending chosen", 12'h607, 12'h000);
        do_ack();
        pulse(16'h0010);
        pulse(16'h6140);
        check("R12 slot held with several pending", 12'h204, 12'h000);
        do_ack();
        check("R7 tie goes to source 6", 12'h406, 12'h000);
        do_ack();
        check("R7 tie goes to source 13", 12'h40D, 12'h000);
        do_ack();
        check("R7 then source 14", 12'h40E, 12'h000);
        do_ack();
        check("R7 zero-priority source 8 never chosen", 12'h000, 12'h000);
    endtask

    task automatic t_disabled_winner();
        do_reset();
        en[10] = 1'b0;
        pulse(16'h0010);
        pulse(16'h0408);
        do_ack();
        check("R8 disabled winner leaves slot empty", 12'h000, 12'h000);
    endtask

    task automatic t_idle_ack();
        do_reset();
        en[3] = 1'b0;
        pulse(16'h0008);
        check("R3 disabled source not loaded", 12'h000, 12'h000);
        en[3] = 1'b1;
        do_ack();
        check("R9 ack with empty slot ignored", 12'h000, 12'h000);
        pulse(16'h0001);
        check("R4 source 0 not loaded", 12'h000, 12'h000);
    endtask

    task automatic t_fast();
        do_reset();
        fast_en = 1'b1; fast_vec = 8'd3;
        pulse(16'h0008);
        check("R5 matching vector on fast line", 12'h000, 12'h503);
        do_ack();
        check("R5 both lines zero after ack", 12'h000, 12'h000);
        pulse(16'h0010);
        check("R5 other vector on normal line", 12'h204, 12'h000);
        fast_vec = 8'd4; fast_en = 1'b0;
        @(negedge clk);
        check("R5 steering disabled", 12'h204, 12'h000);
        fast_en = 1'b1;
        @(negedge clk);
        check("R5 steering follows settings", 12'h000, 12'h204);
    endtask

    task automatic t_level();
        do_reset();
        raise[9] = 1'b1;
        @(negedge clk);
        check("R2 level source presented", 12'h309, 12'h000);
        raise[9] = 1'b0;
        @(negedge clk);
        check("R10 drop clears request", 12'h000, 12'h000);
        raise[9] = 1'b1;
        @(negedge clk);
        do_ack();
        check("R6 level flag kept across ack", 12'h309, 12'h000);
        raise[9] = 1'b0;
        @(negedge clk);
        check("R10 second drop", 12'h000, 12'h000);
    endtask

    initial begin
        for (int i = 0; i < N; i++) map[i*MW +: MW] = MW'(i % NP);
        rst = 1'b1; raise = '0; ack = 1'b0; en = '1; lvl = '0;
        fast_en = 1'b0; fast_vec = '0; prio = '0;
        t_reset_and_basic();
        t_simultaneous();
        t_hold_and_tie();
        t_disabled_winner();
        t_idle_ack();
        t_fast();
        t_level();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule